// File: doc/BRIEF.md
# Dual-Counter Event Monitor

This block counts hardware events for one processor core with two 32-bit counters. Both counters sit side by side in one 64-bit counter register. One 64-bit control register picks the event each counter watches and holds the privilege enables and the interrupt enable. Every clock the core presents a vector of event strobes and its current privilege level. Each counter adds one when its selected strobe is high and the enable bit for the current privilege level is set.

The privilege enables are common to both counters, so one counter cannot be stopped on its own. Software idles a counter by giving it a park code that never counts. Because of this, an overflow interrupt can come from a counter that software is not using. A wrap from all ones to zero, with interrupts enabled, sets a sticky pending flag for that counter. The `irq` output is high while any flag is set. Software clears the flags with a write-one-to-clear access. Software usually loads a counter with the two's complement of a sample period, so that it wraps after that many events.

Top module: `perfmon_dual`

## Requirements
- R1: Address 1 returns the two counters as one 64-bit word: the upper counter in bits 63:32 and the lower counter in bits 31:0.
- R2: A counter goes up by exactly one on a clock edge when its selected strobe is high and counting is allowed. It goes up at most once per clock, and it holds its value otherwise.
- R3: Counting is allowed by one control bit per privilege level, and these bits apply to both counters at once. Level 0 (user) uses bit 2, level 1 (supervisor) uses bit 1 and level 2 (hypervisor) uses bit 3. Level 3 never counts. With bits 3:1 all clear, neither counter moves.
- R4: The lower counter's 6-bit event code is control bits 9:4 and the upper counter's is bits 16:11. A code selects strobe bit `evt_strobe[code]`: code 0 is the cycle strobe and code 1 is the retired-instruction strobe.
- R5: Code 0x14 in the lower field and code 0x1C in the upper field park that counter. A parked counter never counts, even when the strobe at that index is high.
- R6: A write to address 1 updates only the halves whose `wr_half` bit is set: bit 1 selects the upper counter and bit 0 the lower counter. A half that is not selected keeps its value, apart from its own counting.
- R7: When a software write to a counter half and a count land in the same cycle, the half takes the written value and the count is dropped.
- R8: A count that takes a counter from 0xFFFFFFFF to 0 sets that counter's pending flag if control bit 0 (interrupt enable) is set. The upper counter's flag is status bit 1 and the lower counter's flag is status bit 0. `irq` is high whenever any flag is set. With bit 0 clear, the counter still wraps but no flag is set.
- R9: A write to address 2 clears every pending flag whose data bit is 1. If an overflow hits a flag in the same cycle as its clear, the flag stays set.
- R10: A synchronous active-low reset clears both counters, the control register and the pending flags.
- R11: A write to address 0 loads the control register from `wr_data`, whatever the value of `wr_half`. Only bits 3:0, 9:4 and 16:11 are kept. All other bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_level | input | 2 | Current privilege level: 0 user, 1 supervisor, 2 hypervisor, 3 reserved |
| evt_strobe | input | 64 | Per-cycle event strobes, indexed by event code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counters, 2 status |
| wr_half | input | 2 | Counter half select for address 1 (bit 1 upper, bit 0 lower) |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 64 | Read data, combinational from the registers |
| irq | output | 1 | Overflow interrupt, high while any pending flag is set |

## Verification
The bench builds the block with its default parameters: 32-bit counters, 6-bit event fields at bit 4 and bit 11, and park codes 0x14 and 0x1C. These values match the layout the requirements describe. Because the bench can preset a counter, a wrap from all ones to zero is reached in a few cycles. This makes overflow, a clear in the same cycle as an overflow, and a write in the same cycle as a count all directly reachable. Each field boundary in the control word is exercised by the write-mask readback and by moving the event selects across all 64 strobe indices.

// File: rtl/perfmon_pkg.sv
// Shared constants and types for the dual-counter event monitor.
// Assumes a two-bit privilege encoding and a three-entry register map.
package perfmon_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_HYPER = 2'd2,
        PRIV_RSVD  = 2'd3
    } priv_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int IE_BIT = 0;
    localparam int SV_BIT = 1;
    localparam int US_BIT = 2;
    localparam int HV_BIT = 3;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/perfmon_ctrl.sv
// Control register of the event monitor.
// Holds the interrupt enable, the three privilege enables and two event
// selects. Produces the shared count permission for the current level.
// Assumes that the write strobe arriving here is already decoded for
// the control address.
module perfmon_ctrl
    import perfmon_pkg::*;
#(
    parameter int REG_W      = 64,
    parameter int SEL_W      = 6,
    parameter int LO_SEL_LSB = 4,
    parameter int UP_SEL_LSB = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       priv_level,
    output logic [REG_W-1:0] ctrl_q,
    output logic             irq_en,
    output logic             count_ok,
    output logic [SEL_W-1:0] sel_lo,
    output logic [SEL_W-1:0] sel_up
);

    function automatic logic [REG_W-1:0] build_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[IE_BIT] = 1'b1;
        m[SV_BIT] = 1'b1;
        m[US_BIT] = 1'b1;
        m[HV_BIT] = 1'b1;
        for (int i = 0; i < SEL_W; i++) begin
            m[LO_SEL_LSB + i] = 1'b1;
            m[UP_SEL_LSB + i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] CTRL_MASK = build_mask();

    priv_e lvl;
    assign lvl = priv_e'(priv_level);

    // Register update: load only the defined bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    // Field extraction for the counter lanes.
    assign irq_en = ctrl_q[IE_BIT];
    assign sel_lo = ctrl_q[LO_SEL_LSB +: SEL_W];
    assign sel_up = ctrl_q[UP_SEL_LSB +: SEL_W];

    // Shared permission: the enable bit of the current privilege level.
    always_comb begin
        unique case (lvl)
            PRIV_USER:  count_ok = ctrl_q[US_BIT];
            PRIV_SUPER: count_ok = ctrl_q[SV_BIT];
            PRIV_HYPER: count_ok = ctrl_q[HV_BIT];
            default:    count_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/perfmon_counter.sv
// One event counter lane.
// A software write takes priority over an increment. The wrap output
// pulses in the cycle whose increment carries the count from all ones
// to zero.
module perfmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             inc_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    // Count state: reset, load, or add one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_val;
        end else if (inc_req) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wrap detect for an increment that actually takes effect.
    assign wrap = inc_req & ~wr_en & (&cnt_q);

endmodule

// File: rtl/perfmon_pend.sv
// Sticky overflow flags with write-one-to-clear.
// Assumes that a set and a clear of the same flag in one cycle leave the
// flag set.
module perfmon_pend #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_en,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);

    logic [N-1:0] clr_eff;
    assign clr_eff = clr_en ? clr_vec : '0;

    // Flag update: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_eff) | set_vec;
        end
    end

endmodule

// File: rtl/perfmon_dual.sv
// Dual-counter event monitor, top level.
// Two counter lanes share one control register and one privilege
// permission. Each lane counts the strobe its event code selects, unless
// the code is that lane's park code. Wraps with interrupts enabled set
// sticky flags, which drive irq. Read data is combinational.
module perfmon_dual
    import perfmon_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               SEL_W      = 6,
    parameter int               LO_SEL_LSB = 4,
    parameter int               UP_SEL_LSB = 11,
    parameter logic [SEL_W-1:0] LO_PARK    = 6'h14,
    parameter logic [SEL_W-1:0] UP_PARK    = 6'h1C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             priv_level,
    input  logic [(1<<SEL_W)-1:0]  evt_strobe,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [1:0]             wr_half,
    input  logic [2*CNT_W-1:0]     wr_data,
    input  logic [1:0]             rd_addr,
    output logic [2*CNT_W-1:0]     rd_data,
    output logic                   irq
);

    localparam int REG_W = 2 * CNT_W;

    logic [REG_W-1:0]     ctrl_q;
    logic                 irq_en;
    logic                 count_ok;
    logic [SEL_W-1:0]     sel_lo;
    logic [SEL_W-1:0]     sel_up;
    logic [SEL_W-1:0]     lane_sel  [NUM_LANES];
    logic [SEL_W-1:0]     lane_park [NUM_LANES];
    logic [CNT_W-1:0]     lane_cnt  [NUM_LANES];
    logic [NUM_LANES-1:0] lane_wrap;
    logic [NUM_LANES-1:0] pend_set;
    logic [NUM_LANES-1:0] pend_q;
    logic [CNT_W-1:0]     cnt_lo;
    logic [CNT_W-1:0]     cnt_up;
    logic                 ctrl_wr;
    logic                 stat_wr;

    // Address decode for the two non-counter registers.
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign stat_wr = wr_en && (wr_addr == ADDR_STAT);

    perfmon_ctrl #(
        .REG_W      (REG_W),
        .SEL_W      (SEL_W),
        .LO_SEL_LSB (LO_SEL_LSB),
        .UP_SEL_LSB (UP_SEL_LSB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wr_data    (wr_data),
        .priv_level (priv_level),
        .ctrl_q     (ctrl_q),
        .irq_en     (irq_en),
        .count_ok   (count_ok),
        .sel_lo     (sel_lo),
        .sel_up     (sel_up)
    );

    // Lane 0 is the lower counter, lane 1 the upper counter.
    assign lane_sel[0]  = sel_lo;
    assign lane_sel[1]  = sel_up;
    assign lane_park[0] = LO_PARK;
    assign lane_park[1] = UP_PARK;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic lane_inc;
        logic lane_wr;

        // Count request: shared permission, selected strobe, not parked.
        assign lane_inc = count_ok && evt_strobe[lane_sel[g]]
                          && (lane_sel[g] != lane_park[g]);
        assign lane_wr  = wr_en && (wr_addr == ADDR_CNT) && wr_half[g];

        perfmon_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lane_wr),
            .wr_val  (wr_data[g*CNT_W +: CNT_W]),
            .inc_req (lane_inc),
            .cnt_q   (lane_cnt[g]),
            .wrap    (lane_wrap[g])
        );

        assign pend_set[g] = lane_wrap[g] & irq_en;
    end

    perfmon_pend #(
        .N (NUM_LANES)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (pend_set),
        .clr_en  (stat_wr),
        .clr_vec (wr_data[NUM_LANES-1:0]),
        .pend_q  (pend_q)
    );

    assign cnt_lo = lane_cnt[0];
    assign cnt_up = lane_cnt[1];

    // Read multiplexer over the register map.
    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_CNT:  rd_data = {cnt_up, cnt_lo};
            ADDR_STAT: rd_data = {{(REG_W-NUM_LANES){1'b0}}, pend_q};
            default:   rd_data = '0;
        endcase
    end

    assign irq = |pend_q;

endmodule

// File: rtl/perfmon_checker.sv
// Temporal checks on the event monitor, attached through bind.
// It observes the write port, the counter state, the control register and
// the pending flags.
module perfmon_checker #(
    parameter int CNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [1:0]         wr_half,
    input logic [2*CNT_W-1:0] wr_data,
    input logic [2*CNT_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]   cnt_lo,
    input logic [CNT_W-1:0]   cnt_up,
    input logic [1:0]         pend_q
);

    logic lo_wr;
    logic up_wr;
    logic clr0;
    assign lo_wr = wr_en && (wr_addr == 2'd1) && wr_half[0];
    assign up_wr = wr_en && (wr_addr == 2'd1) && wr_half[1];
    assign clr0  = wr_en && (wr_addr == 2'd2) && wr_data[0];

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + 1'b1));

    assert_shared_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3:1] == 3'b000) && !lo_wr |=> $stable(cnt_lo));

    assert_half_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_wr && !lo_wr |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + 1'b1));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> cnt_lo == $past(wr_data[CNT_W-1:0]));

    assert_flag_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[0]) |-> ($past(cnt_lo) == {CNT_W{1'b1}}) && (cnt_lo == '0));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] && !clr0 |=> pend_q[0]);

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_lo == '0) && (cnt_up == '0) && (pend_q == 2'b00)
                         && (ctrl_q == '0));

endmodule

bind perfmon_dual perfmon_checker #(
    .CNT_W (CNT_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_half (wr_half),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .cnt_lo  (cnt_lo),
    .cnt_up  (cnt_up),
    .pend_q  (pend_q)
);

// File: tb/test_perfmon_dual.sv
`timescale 1ns/1ps
module test_perfmon_dual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_level = 2'd0;
    logic [63:0] evt_strobe = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [1:0]  wr_half = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [63:0] rd_data;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // Reference state.
    bit [63:0] m_ctrl = '0;
    bit [31:0] m_lo = '0;
    bit [31:0] m_up = '0;
    bit [1:0]  m_pend = '0;

    localparam bit [63:0] CTRL_KEEP = 64'h1FBFF;   // bits 3:0, 9:4, 16:11 (R11)

    always #10 clk = ~clk;                          // 50 MHz

    perfmon_dual i_perfmon_dual (
        .clk(clk), .rst_n(rst_n), .priv_level(priv_level), .evt_strobe(evt_strobe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_half(wr_half), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input string what, input bit [63:0] act, input bit [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Behavioural next-state from the requirements, evaluated at each edge.
    always @(posedge clk) begin
        bit        ok, inc_l, inc_u, ovf_l, ovf_u, wl, wu;
        bit [5:0]  sl, su;
        bit [31:0] nlo, nup;
        bit [1:0]  clr, setv;
        if (!rst_n) begin
            m_ctrl = '0; m_lo = '0; m_up = '0; m_pend = '0;
        end else begin
            case (priv_level)
                2'd0: ok = m_ctrl[2];
                2'd1: ok = m_ctrl[1];
                2'd2: ok = m_ctrl[3];
                default: ok = 1'b0;
            endcase
            sl = m_ctrl[9:4];
            su = m_ctrl[16:11];
            inc_l = ok && evt_strobe[sl] && (sl != 6'h14);
            inc_u = ok && evt_strobe[su] && (su != 6'h1C);
            wl = wr_en && wr_addr == 2'd1 && wr_half[0];
            wu = wr_en && wr_addr == 2'd1 && wr_half[1];
            ovf_l = 1'b0; ovf_u = 1'b0;
            nlo = m_lo; nup = m_up;
            if (wl) nlo = wr_data[31:0];
            else if (inc_l) begin ovf_l = (m_lo == 32'hFFFF_FFFF); nlo = m_lo + 1; end
            if (wu) nup = wr_data[63:32];
            else if (inc_u) begin ovf_u = (m_up == 32'hFFFF_FFFF); nup = m_up + 1; end
            clr  = (wr_en && wr_addr == 2'd2) ? wr_data[1:0] : 2'b00;
            setv = m_ctrl[0] ? {ovf_u, ovf_l} : 2'b00;
            m_pend = (m_pend & ~clr) | setv;
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data & CTRL_KEEP;
            m_lo = nlo;
            m_up = nup;
        end
    end

    // Compare every register and irq after each edge.
    always @(posedge clk) begin
        #3;
        rd_addr = 2'd0; #1;
        chk(cur_req == "R10" ? "R10" : "R11", "ctrl", rd_data, m_ctrl);
        rd_addr = 2'd1; #1;
        chk(cur_req, "counters(R1)", rd_data, {m_up, m_lo});
        rd_addr = 2'd2; #1;
        chk(cur_req, "status", rd_data, {62'd0, m_pend});
        chk(cur_req, "irq", {63'd0, irq}, {63'd0, |m_pend});
    end

    task automatic step(input bit we, input bit [1:0] a, input bit [1:0] h,
                        input bit [63:0] d, input bit [63:0] stb, input bit [1:0] pl);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_half = h; wr_data = d;
        evt_strobe = stb; priv_level = pl;
    endtask

    task automatic idle(input bit [63:0] stb, input bit [1:0] pl, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 2'd0, 64'd0, stb, pl);
    endtask

    function automatic bit [63:0] mkctrl(input bit ie, input bit s, input bit u, input bit h,
                                         input bit [5:0] lo, input bit [5:0] up);
        return ({63'd0, ie}) | ({63'd0, s} << 1) | ({63'd0, u} << 2) | ({63'd0, h} << 3)
             | ({58'd0, lo} << 4) | ({58'd0, up} << 11);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 3);
        @(negedge clk); rst_n = 1'b1;
        idle(64'd0, 2'd0, 2);

        // R11: write mask on control
        cur_req = "R11";
        step(1'b1, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'd3);
        idle(64'd0, 2'd3, 1);
        rd_addr = 2'd0; #1;
        chk("R11", "ctrl mask readback", rd_data, 64'h1FBFF);

        // R2/R4: user counting, lower=cycles(0), upper=instructions(1)
        cur_req = "R2";
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 0, 1, 0, 6'd0, 6'd1), 64'd0, 2'd0);
        for (int i = 0; i < 8; i++) step(1'b0, 2'd0, 2'd0, 64'd0, {62'd0, i[0], 1'b1}, 2'd0);
        cur_req = "R4";
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 0, 1, 0, 6'd5, 6'd63), 64'd0, 2'd0);
        for (int i = 0; i < 10; i++) step(1'b0, 2'd0, 2'd0, 64'd0, {$urandom, $urandom}, 2'd0);
        idle(64'h8000_0000_0000_0020, 2'd0, 3);

        // R3: privilege enables
        cur_req = "R3";
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 3);
        step(1'b1, 2'd0, 2'd0, mkctrl(0, 1, 0, 1, 6'd0, 6'd0), 64'd0, 2'd0);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 3);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 3);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 3);
        step(1'b1, 2'd0, 2'd0, mkctrl(0, 0, 0, 0, 6'd0, 6'd0), 64'd0, 2'd0);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 3);

        // R5: parked lanes
        cur_req = "R5";
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 1, 1, 1, 6'h14, 6'h1C), 64'd0, 2'd0);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 5);
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 1, 1, 1, 6'h1C, 6'h14), 64'd0, 2'd0);
        idle(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3);

        // R6: half writes while counting
        cur_req = "R6";
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 1, 1, 1, 6'd0, 6'd0), 64'd0, 2'd0);
        step(1'b1, 2'd1, 2'b10, 64'h1234_5678_9ABC_DEF0, 64'd1, 2'd0);
        step(1'b1, 2'd1, 2'b01, 64'hAAAA_AAAA_0000_0100, 64'd1, 2'd0);
        step(1'b1, 2'd1, 2'b00, 64'h5555_5555_5555_5555, 64'd1, 2'd0);
        step(1'b1, 2'd1, 2'b11, 64'h0000_0010_0000_0020, 64'd0, 2'd0);
        idle(64'd0, 2'd0, 1);

        // R7: write and count in the same cycle
        cur_req = "R7";
        step(1'b1, 2'd1, 2'b11, 64'h0000_0007_0000_0009, 64'd1, 2'd0);
        idle(64'd0, 2'd0, 1);
        rd_addr = 2'd1; #1;
        chk("R7", "write beats count", rd_data, 64'h0000_0007_0000_0009);

        // R8: overflow with and without interrupt enable
        cur_req = "R8";
        step(1'b1, 2'd1, 2'b11, 64'hFFFF_FFFE_FFFF_FFFE, 64'd0, 2'd0);
        step(1'b1, 2'd0, 2'd0, mkctrl(0, 0, 1, 0, 6'd0, 6'd2), 64'd0, 2'd0);
        idle(64'd1, 2'd0, 3);
        step(1'b1, 2'd0, 2'd0, mkctrl(1, 0, 1, 0, 6'd0, 6'd2), 64'd0, 2'd0);
        idle(64'd4, 2'd0, 3);
        rd_addr = 2'd2; #1;
        chk("R8", "upper flag", rd_data, 64'd2);

        // R9: clear, and clear colliding with overflow
        cur_req = "R9";
        step(1'b1, 2'd2, 2'd0, 64'd2, 64'd0, 2'd0);
        step(1'b1, 2'd1, 2'b01, 64'h0000_0000_FFFF_FFFF, 64'd0, 2'd0);
        step(1'b1, 2'd2, 2'd0, 64'd1, 64'd1, 2'd0);
        idle(64'd0, 2'd0, 1);
        rd_addr = 2'd2; #1;
        chk("R9", "set beats clear", rd_data, 64'd1);
        step(1'b1, 2'd2, 2'd0, 64'd3, 64'd0, 2'd0);
        idle(64'd0, 2'd0, 2);

        // R2: mixed random traffic with counters near wrap
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit [63:0] d = {$urandom, $urandom};
            if (r < 4)       step(1'b1, 2'd0, 2'd0, d | 64'h1, {$urandom, $urandom}, 2'($urandom));
            else if (r < 9)  step(1'b1, 2'd1, 2'($urandom), d | 64'hFFFF_FFF0_FFFF_FFF0,
                                  {$urandom, $urandom}, 2'($urandom));
            else if (r < 12) step(1'b1, 2'd2, 2'd0, d, {$urandom, $urandom}, 2'($urandom));
            else if (r < 13) step(1'b1, 2'd3, 2'($urandom), d, {$urandom, $urandom}, 2'($urandom));
            else             step(1'b0, 2'd0, 2'd0, d, {$urandom, $urandom}, 2'($urandom));
        end
        idle(64'd0, 2'd0, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule